// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

The walker is the control half of a scatter-gather DMA engine. Software hands it the byte address of a table of 64-bit descriptors, plus a block size and a block count that together give the byte total the whole chain is expected to move. It reads descriptors one at a time over a request/acknowledge memory read port and decodes the attribute bits of each. Every transfer entry becomes one command, an address and a byte length, that goes to a downstream data mover over a valid/ready handshake.

Entries that hold no data are read and passed over. A link entry sends the next fetch to another table. The walk stops at the first entry whose end bit is set. Any entry can ask for a one-cycle interrupt pulse once it completes. Malformed entries stop the walk with a descriptor error. A byte total that differs from the expected total raises a length error. With either error the block records the phase it was in and the descriptor address it was working on.

Top module: `sgw_walker`

## Requirements
- R1: While reset is applied, and after it is released, busy_o, rd_req_o, xfer_valid_o, done_o, irq_o, err_desc_o and err_len_o are all low.
- R2: A descriptor is 64 bits: target address in 63:32, byte length in 31:16, reserved bits 15:6 and bit 3 (all zero), action in bits 5:4, interrupt in bit 2, end in bit 1 and valid in bit 0. The first fetch reads the start address. rd_req_o and rd_addr_o stay stable until rd_ack_i, and rd_req_o is never high in the same cycle as xfer_valid_o.
- R3: After a no-op (action 00), skip (01) or transfer (10) entry that has no end bit, the next descriptor is fetched from the current descriptor address plus 8.
- R4: A transfer entry (action 10) presents its address and length on xfer_addr_o/xfer_len_o with xfer_valid_o. These stay stable until xfer_ready_i, and exactly one command is issued per entry.
- R5: A link entry (action 11) makes its address field the location of the next descriptor fetch.
- R6: An entry with the end bit set stops the walker once that entry completes (for a transfer, once it is accepted). done_o then pulses for one cycle with busy_o low.
- R7: An entry with the interrupt bit set, whatever its action, pulses irq_o for one cycle after it completes.
- R8: An entry with the valid bit clear, or with a reserved bit set, stops the walker with err_desc_o high and no done pulse. err_state_o reads 2 (decode phase) and err_addr_o holds that entry's address.
- R9: A transfer entry whose address or length is not a multiple of 4 issues no command and raises err_desc_o, as in R8.
- R10: When the walk stops at an end entry, the bytes issued are compared with blk_size_i times blk_cnt_i as sampled at start. If they differ, err_len_o rises, err_state_o records the phase of the end entry (2 for decode, 3 for a transfer accepted on the data port) and err_addr_o holds its address. done_o still pulses.
- R11: A start pulse while busy_o is high is ignored. Error flags and their captured state hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, accepted only while idle |
| tbl_base_i | input | 32 | Address of the first descriptor |
| blk_size_i | input | 16 | Block size in bytes for the expected total |
| blk_cnt_i | input | 16 | Block count for the expected total |
| rd_req_o | output | 1 | Descriptor read request |
| rd_addr_o | output | 32 | Descriptor read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| rd_data_i | input | 64 | Descriptor read data |
| xfer_valid_o | output | 1 | Transfer command valid |
| xfer_ready_i | input | 1 | Data mover accepts the command |
| xfer_addr_o | output | 32 | Transfer byte address |
| xfer_len_o | output | 16 | Transfer byte length |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse on stop at an end entry |
| irq_o | output | 1 | One-cycle interrupt pulse |
| err_desc_o | output | 1 | Descriptor error flag |
| err_len_o | output | 1 | Length mismatch flag |
| err_state_o | output | 2 | Walker phase captured at the error |
| err_addr_o | output | 32 | Descriptor address captured at the error |

## Verification
An accepted start shows as busy_o and a read request in the next cycle. A read acknowledged at one edge is decoded in the following cycle, and a transfer command appears the cycle after that. done_o, irq_o and the error flags are registered, so they appear in the cycle after the completing edge. The bench drives the memory and data-mover responses at falling edges and checks every accepted command against its expected queue in the same falling-edge pass, just before the rising edge that takes the command. Counts of done and interrupt pulses and the error state are compared two cycles after busy_o falls.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int DESC_W      = 64;
  localparam int ADDR_W      = 32;
  localparam int LEN_W       = 16;
  localparam int DESC_STRIDE = DESC_W / 8;

  // walker phase; the encoding is visible on err_state_o
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_DECODE = 2'd2,
    ST_MOVE   = 2'd3
  } walk_st_e;

  typedef enum logic [1:0] {
    ACT_NOP  = 2'b00,
    ACT_SKIP = 2'b01,
    ACT_XFER = 2'b10,
    ACT_LINK = 2'b11
  } act_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [9:0]        rsvd;
    logic [1:0]        act;
    logic              zero3;
    logic              irq;
    logic              last;
    logic              valid;
  } desc_t;
endpackage

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
#(
  parameter int ALIGN_LOG2 = 2
) (
  input  logic [DESC_W-1:0] desc_i,
  output logic              valid_o,
  output logic              last_o,
  output logic              irq_o,
  output act_e              act_o,
  output logic              fmt_ok_o,
  output logic              aligned_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [ADDR_W-1:0] AMASK = ADDR_W'((64'd1 << ALIGN_LOG2) - 64'd1);
  localparam logic [LEN_W-1:0]  LMASK = LEN_W'((64'd1 << ALIGN_LOG2) - 64'd1);

  desc_t d;

  always_comb begin
    d         = desc_t'(desc_i);
    valid_o   = d.valid;
    last_o    = d.last;
    irq_o     = d.irq;
    act_o     = act_e'(d.act);
    addr_o    = d.addr;
    len_o     = d.len;
    fmt_ok_o  = (d.rsvd == '0) && !d.zero3;
    aligned_o = ((d.addr & AMASK) == '0) && ((d.len & LMASK) == '0);
  end
endmodule

// File: rtl/sgw_tally.sv
module sgw_tally #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [LEN_W-1:0] bsz_i,
  input  logic [LEN_W-1:0] bcnt_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             mismatch_o
);
  logic [CNT_W-1:0] expect_q, expect_n;
  logic [CNT_W-1:0] total_q, total_n;
  logic [CNT_W-1:0] sum_now;
  logic             tot_en;

  always_comb begin
    sum_now    = total_q + (add_i ? CNT_W'(len_i) : '0);
    expect_n   = CNT_W'(bsz_i) * CNT_W'(bcnt_i);
    tot_en     = clr_i | add_i;
    total_n    = clr_i ? '0 : sum_now;
    mismatch_o = (sum_now != expect_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q <= '0;
      total_q  <= '0;
    end else begin
      if (clr_i)  expect_q <= expect_n;
      if (tot_en) total_q  <= total_n;
    end
  end
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DESC_W-1:0] rd_data_i,
  output logic [DESC_W-1:0] desc_o,
  input  logic              d_valid_i,
  input  logic              d_last_i,
  input  logic              d_irq_i,
  input  act_e              d_act_i,
  input  logic              d_fmt_ok_i,
  input  logic              d_aligned_i,
  input  logic [ADDR_W-1:0] d_addr_i,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic              tally_clr_o,
  output logic              tally_add_o,
  input  logic              mismatch_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              err_desc_o,
  output logic              err_len_o,
  output logic [1:0]        err_state_o,
  output logic [ADDR_W-1:0] err_addr_o
);
  walk_st_e          state_q, state_n;
  logic [ADDR_W-1:0] tbl_q, tbl_n;
  logic [DESC_W-1:0] desc_q;
  logic              desc_en;
  logic              done_q, done_n, irq_q, irq_n;
  logic              edesc_q, edesc_n, elen_q, elen_n;
  walk_st_e          est_q, est_n;
  logic [ADDR_W-1:0] eaddr_q, eaddr_n;
  logic              finish, bad;

  always_comb begin
    state_n     = state_q;
    tbl_n       = tbl_q;
    desc_en     = 1'b0;
    done_n      = 1'b0;
    irq_n       = 1'b0;
    edesc_n     = edesc_q;
    elen_n      = elen_q;
    est_n       = est_q;
    eaddr_n     = eaddr_q;
    tally_clr_o = 1'b0;
    tally_add_o = 1'b0;
    finish      = 1'b0;
    bad         = !d_valid_i || !d_fmt_ok_i || (d_act_i == ACT_XFER && !d_aligned_i);

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n     = ST_FETCH;
          tbl_n       = base_i;
          tally_clr_o = 1'b1;
          edesc_n     = 1'b0;
          elen_n      = 1'b0;
          est_n       = ST_IDLE;
          eaddr_n     = '0;
        end
      end
      ST_FETCH: begin
        if (rd_ack_i) begin
          desc_en = 1'b1;
          state_n = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (bad) begin
          state_n = ST_IDLE;
          edesc_n = 1'b1;
          est_n   = ST_DECODE;
          eaddr_n = tbl_q;
        end else if (d_act_i == ACT_XFER) begin
          state_n = ST_MOVE;
        end else begin
          finish = 1'b1;
        end
      end
      ST_MOVE: begin
        if (xfer_ready_i) begin
          tally_add_o = 1'b1;
          finish      = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase

    if (finish) begin
      irq_n = d_irq_i;
      if (d_last_i) begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
        if (mismatch_i) begin
          elen_n  = 1'b1;
          est_n   = state_q;
          eaddr_n = tbl_q;
        end
      end else begin
        state_n = ST_FETCH;
        tbl_n   = (d_act_i == ACT_LINK) ? d_addr_i : tbl_q + ADDR_W'(DESC_STRIDE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tbl_q   <= '0;
      desc_q  <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      edesc_q <= 1'b0;
      elen_q  <= 1'b0;
      est_q   <= ST_IDLE;
      eaddr_q <= '0;
    end else begin
      state_q <= state_n;
      tbl_q   <= tbl_n;
      if (desc_en) desc_q <= rd_data_i;
      done_q  <= done_n;
      irq_q   <= irq_n;
      edesc_q <= edesc_n;
      elen_q  <= elen_n;
      est_q   <= est_n;
      eaddr_q <= eaddr_n;
    end
  end

  assign rd_req_o     = (state_q == ST_FETCH);
  assign rd_addr_o    = tbl_q;
  assign desc_o       = desc_q;
  assign xfer_valid_o = (state_q == ST_MOVE);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign irq_o        = irq_q;
  assign err_desc_o   = edesc_q;
  assign err_len_o    = elen_q;
  assign err_state_o  = est_q;
  assign err_addr_o   = eaddr_q;
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int ALIGN_LOG2 = 2,
  parameter int CNT_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    tbl_base_i,
  input  logic [LEN_W-1:0]     blk_size_i,
  input  logic [LEN_W-1:0]     blk_cnt_i,
  output logic                 rd_req_o,
  output logic [ADDR_W-1:0]    rd_addr_o,
  input  logic                 rd_ack_i,
  input  logic [DESC_W-1:0]    rd_data_i,
  output logic                 xfer_valid_o,
  input  logic                 xfer_ready_i,
  output logic [ADDR_W-1:0]    xfer_addr_o,
  output logic [LEN_W-1:0]     xfer_len_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 irq_o,
  output logic                 err_desc_o,
  output logic                 err_len_o,
  output logic [1:0]           err_state_o,
  output logic [ADDR_W-1:0]    err_addr_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [DESC_W-1:0] desc;
  logic              d_valid, d_last, d_irq, d_fmt_ok, d_aligned;
  act_e              d_act;
  logic [ADDR_W-1:0] d_addr;
  logic [LEN_W-1:0]  d_len;
  logic              t_clr, t_add, t_mis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sgw_decode #(.ALIGN_LOG2(ALIGN_LOG2)) u_dec (
    .desc_i(desc), .valid_o(d_valid), .last_o(d_last), .irq_o(d_irq),
    .act_o(d_act), .fmt_ok_o(d_fmt_ok), .aligned_o(d_aligned),
    .addr_o(d_addr), .len_o(d_len)
  );

  sgw_tally #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_tally (
    .clk(clk), .rst_n(rst_int_n), .clr_i(t_clr), .bsz_i(blk_size_i),
    .bcnt_i(blk_cnt_i), .add_i(t_add), .len_i(d_len), .mismatch_o(t_mis)
  );

  sgw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .base_i(tbl_base_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .desc_o(desc),
    .d_valid_i(d_valid), .d_last_i(d_last), .d_irq_i(d_irq), .d_act_i(d_act),
    .d_fmt_ok_i(d_fmt_ok), .d_aligned_i(d_aligned), .d_addr_i(d_addr),
    .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .tally_clr_o(t_clr), .tally_add_o(t_add), .mismatch_i(t_mis),
    .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o),
    .err_desc_o(err_desc_o), .err_len_o(err_len_o),
    .err_state_o(err_state_o), .err_addr_o(err_addr_o)
  );

  assign xfer_addr_o = d_addr;
  assign xfer_len_o  = d_len;
endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req_o,
  input logic        rd_ack_i,
  input logic [31:0] rd_addr_o,
  input logic        xfer_valid_o,
  input logic        xfer_ready_i,
  input logic [31:0] xfer_addr_o,
  input logic [15:0] xfer_len_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        irq_o,
  input logic        err_desc_o,
  input logic        err_len_o
);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  // R2
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && xfer_valid_o));
  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_len_o));
  // R9
  xfer_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (xfer_addr_o[1:0] == 2'b00) && (xfer_len_o[1:0] == 2'b00));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_desc_o || err_len_o) |-> !busy_o);
endmodule

bind sgw_walker sgw_walker_chk chk_i (.*);

// File: tb/sgw_walker_test.sv
`timescale 1ns/1ps
module sgw_walker_test;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] tbl_base_i;
  logic [15:0] blk_size_i, blk_cnt_i;
  logic        rd_req_o, rd_ack_i;
  logic [31:0] rd_addr_o;
  logic [63:0] rd_data_i;
  logic        xfer_valid_o, xfer_ready_i;
  logic [31:0] xfer_addr_o;
  logic [15:0] xfer_len_o;
  logic        busy_o, done_o, irq_o, err_desc_o, err_len_o;
  logic [1:0]  err_state_o;
  logic [31:0] err_addr_o;

  sgw_walker uut (.*);

  typedef struct { logic [31:0] a; logic [15:0] l; } exp_t;
  exp_t        q[$];
  exp_t        pop_e;
  logic [63:0] mem [0:127];
  int          n_chk, n_fail, n_irq, n_done;
  bit          rdy_alt, rdy_ph;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] mk(logic [31:0] a, logic [15:0] l, logic [1:0] act,
                                     bit e, bit i, bit v);
    return {a, l, 10'd0, act, 1'b0, i, e, v};
  endfunction

  task automatic push(logic [31:0] a, logic [15:0] l);
    exp_t e;
    e.a = a; e.l = l;
    q.push_back(e);
  endtask

  // memory responder, data mover and scoreboard monitor, all at falling edges
  always @(negedge clk) begin
    if (rd_req_o && !rd_ack_i) begin
      rd_ack_i  = 1'b1;
      rd_data_i = mem[rd_addr_o[9:3]];
    end else begin
      rd_ack_i  = 1'b0;
    end
    if (rdy_alt) rdy_ph = !rdy_ph; else rdy_ph = 1'b1;
    xfer_ready_i = rdy_ph;
    if (xfer_valid_o && xfer_ready_i) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4", "unexpected command", {32'h0, xfer_addr_o}, 64'h0);
      end else begin
        pop_e = q.pop_front();
        chk(xfer_addr_o == pop_e.a, "R4", "xfer addr", {32'h0, xfer_addr_o}, {32'h0, pop_e.a});
        chk(xfer_len_o == pop_e.l, "R4", "xfer len", {48'h0, xfer_len_o}, {48'h0, pop_e.l});
      end
    end
    if (done_o) n_done++;
    if (irq_o)  n_irq++;
  end

  task automatic run(logic [31:0] base, logic [15:0] bsz, logic [15:0] bcnt, bit alt, bit restart);
    rdy_alt = alt; n_irq = 0; n_done = 0;
    @(negedge clk);
    tbl_base_i = base; blk_size_i = bsz; blk_cnt_i = bcnt; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (restart) begin
      repeat (2) @(negedge clk);
      chk(busy_o == 1'b1, "R11", "busy at second start", {63'h0, busy_o}, 64'h1);
      tbl_base_i = 32'h200; blk_size_i = 16'd1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fin(string req, int e_irq, int e_done, bit e_desc, bit e_len,
                     logic [1:0] e_st, logic [31:0] e_addr);
    chk(q.size() == 0, req, "commands left", 64'(q.size()), 64'h0);
    chk(n_irq == e_irq, req, "irq pulses", 64'(n_irq), 64'(e_irq));
    chk(n_done == e_done, req, "done pulses", 64'(n_done), 64'(e_done));
    chk(err_desc_o == e_desc, req, "err_desc", {63'h0, err_desc_o}, {63'h0, e_desc});
    chk(err_len_o == e_len, req, "err_len", {63'h0, err_len_o}, {63'h0, e_len});
    if (e_desc || e_len) begin
      chk(err_state_o == e_st, req, "err_state", {62'h0, err_state_o}, {62'h0, e_st});
      chk(err_addr_o == e_addr, req, "err_addr", {32'h0, err_addr_o}, {32'h0, e_addr});
    end
    q.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; n_irq = 0; n_done = 0;
    rdy_alt = 0; rdy_ph = 1;
    rst_n = 1'b0; start_i = 1'b0; tbl_base_i = '0; blk_size_i = '0; blk_cnt_i = '0;
    rd_ack_i = 1'b0; rd_data_i = '0; xfer_ready_i = 1'b1;
    for (int i = 0; i < 128; i++) mem[i] = 64'h0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy_o && !rd_req_o && !xfer_valid_o, "R1", "idle in reset",
        {61'h0, busy_o, rd_req_o, xfer_valid_o}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !rd_req_o && !xfer_valid_o && !done_o && !irq_o, "R1", "idle after reset",
        {59'h0, busy_o, rd_req_o, xfer_valid_o, done_o, irq_o}, 64'h0);
    chk(!err_desc_o && !err_len_o, "R1", "errors after reset",
        {62'h0, err_desc_o, err_len_o}, 64'h0);

    // tables
    mem[0]   = mk(32'h1000, 16'd16, 2'b10, 0, 0, 1);
    mem[1]   = mk(32'h2000, 16'd32, 2'b10, 0, 1, 1);
    mem[2]   = mk(32'h3000, 16'd16, 2'b10, 1, 0, 1);
    mem[8]   = mk(32'h0,    16'd0,  2'b00, 0, 1, 1);
    mem[9]   = mk(32'h0,    16'd0,  2'b01, 0, 0, 1);
    mem[10]  = mk(32'h100,  16'd0,  2'b11, 0, 0, 1);
    mem[11]  = mk(32'hDEA0, 16'd4,  2'b10, 1, 0, 1);
    mem[32]  = mk(32'h4000, 16'd8,  2'b10, 0, 0, 1);
    mem[33]  = mk(32'h4100, 16'd8,  2'b10, 1, 0, 1);
    mem[64]  = mk(32'h5000, 16'd4,  2'b10, 0, 0, 1);
    mem[65]  = mk(32'h5004, 16'd4,  2'b10, 1, 0, 0);
    mem[80]  = mk(32'h5100, 16'd4,  2'b10, 1, 0, 1) | 64'h100;
    mem[88]  = mk(32'h6002, 16'd8,  2'b10, 1, 0, 1);
    mem[96]  = mk(32'h6000, 16'd6,  2'b10, 1, 0, 1);
    mem[104] = mk(32'h7000, 16'd12, 2'b10, 1, 0, 1);
    mem[112] = mk(32'h7100, 16'd4,  2'b10, 0, 0, 1);
    mem[113] = mk(32'h0,    16'd0,  2'b00, 1, 0, 1);
    mem[120] = mk(32'h8000, 16'd4,  2'b10, 0, 0, 1);
    mem[121] = mk(32'h8004, 16'd4,  2'b10, 1, 1, 1);

    // R3 R4 R6 R7: sequential transfers, interrupt mid-chain, matching total
    push(32'h1000, 16'd16); push(32'h2000, 16'd32); push(32'h3000, 16'd16);
    run(32'h000, 16'd16, 16'd4, 0, 0);
    fin("R3", 1, 1, 0, 0, 2'd0, 32'h0);

    // R3 R5 R7: no-op with interrupt, skip, link to a second table, stalled mover
    push(32'h4000, 16'd8); push(32'h4100, 16'd8);
    run(32'h040, 16'd8, 16'd2, 1, 0);
    fin("R5", 1, 1, 0, 0, 2'd0, 32'h0);

    // R8: entry with valid clear after one good transfer
    push(32'h5000, 16'd4);
    run(32'h200, 16'd4, 16'd2, 0, 0);
    fin("R8", 0, 0, 1, 0, 2'd2, 32'h208);

    // R8: reserved bit set
    run(32'h280, 16'd4, 16'd1, 0, 0);
    fin("R8", 0, 0, 1, 0, 2'd2, 32'h280);

    // R9: misaligned address, then misaligned length
    run(32'h2C0, 16'd8, 16'd1, 0, 0);
    fin("R9", 0, 0, 1, 0, 2'd2, 32'h2C0);
    run(32'h300, 16'd6, 16'd1, 0, 0);
    fin("R9", 0, 0, 1, 0, 2'd2, 32'h300);

    // R10: short total, end on a transfer
    push(32'h7000, 16'd12);
    run(32'h340, 16'd16, 16'd1, 1, 0);
    fin("R10", 0, 1, 0, 1, 2'd3, 32'h340);

    // R10: short total, end on a no-op
    push(32'h7100, 16'd4);
    run(32'h380, 16'd8, 16'd1, 0, 0);
    fin("R10", 0, 1, 0, 1, 2'd2, 32'h388);

    // R11: flags held while idle, cleared by next start, restart while busy ignored
    repeat (5) @(negedge clk);
    chk(err_len_o == 1'b1, "R11", "err_len held while idle", {63'h0, err_len_o}, 64'h1);
    push(32'h8000, 16'd4); push(32'h8004, 16'd4);
    run(32'h3C0, 16'd4, 16'd2, 1, 1);
    fin("R11", 1, 1, 0, 0, 2'd0, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule